// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

This block is a small arithmetic peripheral on a byte-wide register bus. A host writes operands into byte registers. Writing the last operand of an operation starts it: the multiplier byte for an 8x8 unsigned multiply, or the divisor byte for a 16/8 unsigned divide. The unit then works one bit per clock. It produces a 16-bit product after 8 cycles, or a 16-bit quotient and a 16-bit remainder after 16 cycles.

Results are read back through a separate read map. One 16-bit result register belongs only to the quotient. A second 16-bit result register is shared: it shows the product after a multiply and the remainder after a divide, whichever operation was started last. A start of either operation cancels any operation still in progress. A `busy_o` output shows whether an operation is running.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, all four result bytes read 0 and `busy_o` is 0.
- R2: Writing the multiplier (write address 1) starts an unsigned multiply of that byte by the byte last written to address 0. The 16-bit product is readable at the 8th rising edge after the write edge.
- R3: Writing the divisor (write address 4) starts an unsigned divide of the 16-bit dividend (low byte at write address 2, high byte at write address 3) by that byte. The quotient and remainder are readable at the 16th rising edge after the write edge.
- R4: The read map is as follows while `rd_i` is 1. Address 0 gives the quotient low byte and address 1 the quotient high byte. Address 2 gives the shared result low byte and address 3 the shared result high byte. Addresses 4 to 7 read 0. With `rd_i` at 0, `rdata_o` is 0.
- R5: Writes to addresses 5, 6 and 7 have no effect: they start nothing and change no result.
- R6: A divisor of 0 yields a quotient of 0xFFFF and a remainder equal to the dividend, with the normal 16-cycle latency.
- R7: Writing the start register of the operation already running restarts it with the new operands and a fresh cycle count.
- R8: Starting one operation stops the other one. The shared result register shows the product after a multiply start and the remainder after a divide start. A multiply leaves the quotient unchanged.
- R9: Operand writes that do not start an operation do not affect a running operation. Finished results hold until the next start.
- R10: `busy_o` is 1 from the edge that takes a start write until the edge that completes the operation, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address for reads and writes |
| wr_i | input | 1 | Write strobe, sampled at the rising edge |
| rd_i | input | 1 | Read strobe; enables `rdata_o` |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data byte, combinational from `addr_i` |
| busy_o | output | 1 | An operation is in progress |

## Verification
The hardest situations to reach are those where a start write arrives while an operation is running. They must be timed against the internal step count, which the ports show only through `busy_o`. The bench places such writes a counted number of negative edges after a start: a second multiplier write, a multiply start during a divide, and a divide start during a multiply. It then checks that the latency is measured from the second start and that the shared register follows it. The arithmetic is swept over every multiplicand against a set of edge-value multipliers. It is also swept over every divisor, including zero, against boundary dividends.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    WA_MCAND  = 3'd0,
    WA_MPLIER = 3'd1,
    WA_DVD_LO = 3'd2,
    WA_DVD_HI = 3'd3,
    WA_DVSR   = 3'd4
  } wr_addr_e;

  typedef enum logic [ADDR_W-1:0] {
    RA_QUO_LO = 3'd0,
    RA_QUO_HI = 3'd1,
    RA_SHR_LO = 3'd2,
    RA_SHR_HI = 3'd3
  } rd_addr_e;
endpackage

// File: rtl/muldiv_regs.sv
module muldiv_regs
  import muldiv_pkg::*;
#(
  parameter  int OP_W  = 8,
  localparam int DVD_W = 2*OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [OP_W-1:0]   wdata_i,
  output logic [OP_W-1:0]   mcand_o,
  output logic [DVD_W-1:0]  dividend_o,
  output logic              start_mul_o,
  output logic              start_div_o
);
  logic [OP_W-1:0] mcand_q, dvd_lo_q, dvd_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      dvd_lo_q <= '0;
      dvd_hi_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        WA_MCAND:  mcand_q  <= wdata_i;
        WA_DVD_LO: dvd_lo_q <= wdata_i;
        WA_DVD_HI: dvd_hi_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // start byte itself is taken straight from wdata_i by the cores
  assign start_mul_o = wr_i && (addr_i == WA_MPLIER);
  assign start_div_o = wr_i && (addr_i == WA_DVSR);
  assign mcand_o     = mcand_q;
  assign dividend_o  = {dvd_hi_q, dvd_lo_q};
endmodule

// File: rtl/muldiv_mul_core.sv
module muldiv_mul_core #(
  parameter  int OP_W  = 8,
  localparam int PRD_W = 2*OP_W,
  localparam int CNT_W = $clog2(OP_W+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [OP_W-1:0]  mcand_i,
  input  logic [OP_W-1:0]  mplier_i,
  output logic             busy_o,
  output logic [PRD_W-1:0] prod_o
);
  logic [PRD_W-1:0] acc_q, mcand_q;
  logic [OP_W-1:0]  mplier_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  // LSB-first shift-and-add, one multiplier bit per cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
    end else if (start_i) begin
      acc_q    <= '0;
      mcand_q  <= {{OP_W{1'b0}}, mcand_i};
      mplier_q <= mplier_i;
      cnt_q    <= CNT_W'(OP_W);
      busy_q   <= 1'b1;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (mplier_q[0]) acc_q <= acc_q + mcand_q;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
      cnt_q    <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign prod_o = acc_q;

  assert_mul_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q);
  assert_mul_last_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i && !abort_i && cnt_q == CNT_W'(1)) |=> !busy_q);
  assert_mul_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> $stable(acc_q));
endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core #(
  parameter  int OP_W  = 8,
  localparam int DVD_W = 2*OP_W,
  localparam int CNT_W = $clog2(DVD_W+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [OP_W-1:0]  divisor_i,
  output logic             busy_o,
  output logic [DVD_W-1:0] quo_o,
  output logic [DVD_W-1:0] rem_o
);
  logic [OP_W-1:0]  dvs_q;
  logic [DVD_W-1:0] quo_q, rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [DVD_W:0]   trial, diff;
  logic             ge;

  // restoring step; full-width remainder lets a zero divisor fall out naturally
  always_comb begin
    trial = {rem_q, quo_q[DVD_W-1]};
    ge    = trial >= {{(DVD_W-OP_W+1){1'b0}}, dvs_q};
    diff  = trial - {{(DVD_W-OP_W+1){1'b0}}, dvs_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvs_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      dvs_q  <= divisor_i;
      quo_q  <= dividend_i;
      rem_q  <= '0;
      cnt_q  <= CNT_W'(DVD_W);
      busy_q <= 1'b1;
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      rem_q <= ge ? diff[DVD_W-1:0] : trial[DVD_W-1:0];
      quo_q <= {quo_q[DVD_W-2:0], ge};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;

  assert_div_start_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q);
  assert_div_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i && !abort_i && cnt_q == CNT_W'(1) && dvs_q == '0)
    |=> (quo_q == '1 && !busy_q));
  assert_div_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !start_i) |=> !busy_q);
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter  int OP_W  = 8,
  localparam int DVD_W = 2*OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [OP_W-1:0]   wdata_i,
  output logic [OP_W-1:0]   rdata_o,
  output logic              busy_o
);
  logic [OP_W-1:0]  mcand;
  logic [DVD_W-1:0] dividend, prod, quo, rem, shared;
  logic             start_mul, start_div, mul_busy, div_busy, sel_div_q;

  muldiv_regs #(.OP_W(OP_W)) i_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .mcand_o(mcand), .dividend_o(dividend),
    .start_mul_o(start_mul), .start_div_o(start_div)
  );

  muldiv_mul_core #(.OP_W(OP_W)) i_mul (
    .clk_i, .rst_ni, .start_i(start_mul), .abort_i(start_div),
    .mcand_i(mcand), .mplier_i(wdata_i),
    .busy_o(mul_busy), .prod_o(prod)
  );

  muldiv_div_core #(.OP_W(OP_W)) i_div (
    .clk_i, .rst_ni, .start_i(start_div), .abort_i(start_mul),
    .dividend_i(dividend), .divisor_i(wdata_i),
    .busy_o(div_busy), .quo_o(quo), .rem_o(rem)
  );

  // shared result follows the most recently started operation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sel_div_q <= 1'b0;
    else if (start_div) sel_div_q <= 1'b1;
    else if (start_mul) sel_div_q <= 1'b0;
  end

  assign shared = sel_div_q ? rem : prod;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        RA_QUO_LO: rdata_o = quo[OP_W-1:0];
        RA_QUO_HI: rdata_o = quo[DVD_W-1:OP_W];
        RA_SHR_LO: rdata_o = shared[OP_W-1:0];
        RA_SHR_HI: rdata_o = shared[DVD_W-1:OP_W];
        default:   rdata_o = '0;
      endcase
    end
  end

  assign busy_o = mul_busy | div_busy;

  assert_one_core_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mul_busy && div_busy));
  assert_quo_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_mul && !div_busy) |=> $stable(quo));
  assert_busy_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_mul || start_div) |=> busy_o);
endmodule

// File: tb/test_muldiv_unit.sv
`timescale 1ns/1ps
module test_muldiv_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       busy_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  muldiv_unit i_muldiv_unit (.*);

  task automatic check(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    addr_i = a[2:0]; wdata_i = d[7:0]; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd8(input int a, output int v);
    rd_i = 1'b1; addr_i = a[2:0];
    #0.1;
    v = int'(rdata_o);
    rd_i = 1'b0;
  endtask

  task automatic rd16(input int a, output int v);
    int lo, hi;
    rd8(a, lo);
    rd8(a + 1, hi);
    v = (hi << 8) | lo;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_mul(input int a, input int b);
    int v;
    wr(0, a);
    wr(1, b);
    edges(7);
    check(int'(busy_o), 1, "R10 busy before 8th edge");
    edges(1);
    check(int'(busy_o), 0, "R10 busy after mul");
    rd16(2, v);
    check(v, a * b, "R2 product");
  endtask

  task automatic do_div(input int n, input int d);
    int q, r;
    wr(2, n & 8'hff);
    wr(3, n >> 8);
    wr(4, d);
    edges(15);
    check(int'(busy_o), 1, "R10 busy before 16th edge");
    edges(1);
    rd16(0, q);
    rd16(2, r);
    if (d == 0) begin
      check(q, 16'hffff, "R6 quotient on zero divisor");
      check(r, n, "R6 remainder on zero divisor");
    end else begin
      check(q, n / d, "R3 quotient");
      check(r, n % d, "R3 remainder");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int v, q, r;
    int bset [8] = '{0, 1, 2, 85, 127, 128, 170, 255};
    int nset [12] = '{0, 1, 7, 255, 256, 1000, 4095, 12345, 32768, 40000, 65534, 65535};
    edges(3);
    rst_ni = 1'b1;
    edges(1);

    // R1 reset state
    check(int'(busy_o), 0, "R1 busy after reset");
    for (int a = 0; a < 4; a++) begin
      rd8(a, v);
      check(v, 0, "R1 result byte after reset");
    end

    // R2 multiply sweep
    for (int a = 0; a < 256; a++)
      for (int i = 0; i < 8; i++) do_mul(a, bset[i]);

    // R3 / R6 divide sweep over every divisor
    foreach (nset[i])
      for (int d = 0; d < 256; d++) do_div(nset[i], d);

    // R4 read map: unused addresses and idle strobe
    for (int a = 4; a < 8; a++) begin
      rd8(a, v);
      check(v, 0, "R4 unused read address");
    end
    addr_i = 3'd0; rd_i = 1'b0; #0.1;
    check(int'(rdata_o), 0, "R4 rdata with rd_i low");

    // R5 writes to unused addresses: last div was 65535/255 -> q 257 r 0
    wr(5, 8'h5a); wr(6, 8'ha5); wr(7, 8'hff);
    check(int'(busy_o), 0, "R5 no start from unused address");
    edges(20);
    rd16(0, q); rd16(2, r);
    check(q, 257, "R5 quotient untouched");
    check(r, 0, "R5 shared untouched");

    // R9 non-start writes during a multiply, then hold
    wr(0, 10); wr(1, 20);
    wr(0, 255); wr(2, 8'h12); wr(3, 8'h34);
    edges(5);
    rd16(2, v);
    check(v, 200, "R9 product despite operand writes");
    check(int'(busy_o), 0, "R9 busy after mul");
    edges(30);
    rd16(2, v);
    check(v, 200, "R9 product held");

    // R7 restart of a running multiply
    wr(0, 3); wr(1, 5);
    edges(3);
    wr(1, 7);
    edges(7);
    check(int'(busy_o), 1, "R7 busy counts from restart");
    edges(1);
    check(int'(busy_o), 0, "R7 done 8 edges after restart");
    rd16(2, v);
    check(v, 21, "R7 product of restarted operands");

    // R8 multiply leaves quotient, then multiply aborts a divide
    do_div(1000, 7);
    do_mul(12, 13);
    rd16(0, q);
    check(q, 142, "R8 quotient kept across multiply");
    wr(2, 5000 & 8'hff); wr(3, 5000 >> 8); wr(4, 9);
    edges(4);
    wr(0, 12); wr(1, 13);
    edges(8);
    check(int'(busy_o), 0, "R8 divide stopped by multiply");
    rd16(2, v);
    check(v, 156, "R8 shared shows product");

    // R8 divide aborts a multiply
    wr(0, 200); wr(1, 201);
    edges(3);
    wr(4, 9);
    edges(15);
    check(int'(busy_o), 1, "R8 divide running after abort");
    edges(1);
    check(int'(busy_o), 0, "R8 divide done");
    rd16(0, q); rd16(2, r);
    check(q, 555, "R8 quotient after abort");
    check(r, 5, "R8 shared shows remainder");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule